// File: doc/BRIEF.md
# Quadword Write Assembler

This block gathers byte writes of any length from 1 to 16 bytes into one 128-bit quadword. When every byte of the quadword is present, it hands the quadword to a small instruction queue. Each write gives a lane offset (the low address bits inside the 16-byte window), a byte count and right-aligned data. Byte k of the data lands in lane offset+k of a holding register. A 16-bit lane map records which lanes hold fresh bytes.

While any lane is still unwritten, the write is absorbed and nothing is queued. The write that fills the last lane clears the lane map and moves the full quadword into a one-entry staging slot. The next cycle the staging slot enters the queue, tagged with the source address presented on that cycle. When the queue is full, the staged quadword waits and the write port stays closed. A clear command throws away a partly gathered quadword. The consumer pops entries in arrival order.

Top module: `qw_assembler`

## Requirements
- R1: Byte k of `wr_data` (bits 8k+7..8k) is stored in lane `wr_lane`+k, and lane n occupies bits 8n+7..8n of the queued quadword.
- R2: A write accepted while any lane is still unwritten queues nothing, and `rd_valid` stays low.
- R3: The write that fills the 16th lane clears the lane map. The gathered quadword appears at the queue head two clock edges after that write is accepted, provided the queue has room.
- R4: Each queued entry carries the `src_addr` value present in the cycle the entry enters the queue.
- R5: Writing a lane that already holds a byte replaces that byte, and the lane still counts as written.
- R6: A write with a byte count of 0, or one whose offset plus byte count exceeds 16, changes no lane and no lane-map bit. It raises `wr_err` in the cycle after acceptance.
- R7: A one-cycle `clear_cmd` empties the lane map, so all 16 lanes must be written again before anything is queued. `wr_ready` is low while `clear_cmd` is high.
- R8: With the queue full, a completed quadword is held, `wr_ready` stays low until it enters the queue, and `fifo_full` is high while the queue holds DEPTH entries.
- R9: Entries leave the queue in the order they were completed, one per cycle in which `rd_pop` is high and `rd_valid` is high.
- R10: After reset the lane map and queue are empty, `wr_ready` is high, and `rd_valid`, `wr_err` and `fifo_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write port can accept |
| wr_lane | input | 4 | Starting byte lane (address offset in the quadword) |
| wr_len | input | 5 | Number of bytes, 1 to 16 |
| wr_data | input | 128 | Right-aligned write bytes |
| wr_err | output | 1 | Rejected-write pulse, one cycle after acceptance |
| clear_cmd | input | 1 | Discard the partly gathered quadword |
| src_addr | input | 32 | Source tag sampled when an entry is queued |
| rd_pop | input | 1 | Remove the head entry |
| rd_valid | output | 1 | Queue head is valid |
| rd_data | output | 128 | Head quadword |
| rd_src | output | 32 | Head source tag |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_level | output | clog2(DEPTH+1) | Number of queued entries |

## Verification
A stale lane-map bit shows up as a quadword that is queued too early or never queued, within two edges of the write that should or should not finish it. A wrong lane mapping or a lost overwrite shows up as wrong bytes at the head. A rejected write that leaks into the holding register corrupts the next queued quadword. A staging or queue-count fault shows up as a wrong `wr_ready` or `fifo_full`, or as an entry out of order when the queue drains.

// File: rtl/qw_asm_pkg.sv
package qw_asm_pkg;
    localparam int LANES  = 16;
    localparam int LANE_W = 8;
    localparam int QW_W   = LANES * LANE_W;
    localparam int OFS_W  = $clog2(LANES);
    localparam int LEN_W  = $clog2(LANES) + 1;
    localparam int SRC_W  = 32;

    typedef logic [LANES-1:0] lane_map_t;
    typedef logic [QW_W-1:0]  qword_t;

    typedef struct packed {
        qword_t             data;
        logic [SRC_W-1:0]   src;
    } q_entry_t;

    // A write is legal when it has bytes and stays inside the quadword.
    function automatic logic span_legal(input logic [OFS_W-1:0] ofs,
                                        input logic [LEN_W-1:0] len);
        return (len != '0) && ((int'(ofs) + int'(len)) <= LANES);
    endfunction

    function automatic lane_map_t span_lanes(input logic [OFS_W-1:0] ofs,
                                             input logic [LEN_W-1:0] len);
        lane_map_t m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            if (l >= int'(ofs) && l < int'(ofs) + int'(len))
                m[l] = 1'b1;
        end
        return m;
    endfunction

    function automatic qword_t place_bytes(input qword_t hold,
                                           input lane_map_t sel,
                                           input logic [OFS_W-1:0] ofs,
                                           input qword_t data);
        qword_t r;
        int     k;
        r = hold;
        for (int l = 0; l < LANES; l++) begin
            if (sel[l]) begin
                k = l - int'(ofs);
                r[l*LANE_W +: LANE_W] = data[k*LANE_W +: LANE_W];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/qw_lane_merge.sv
module qw_lane_merge
    import qw_asm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic                 clear,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [LEN_W-1:0]     len,
    input  qword_t               data,
    output qword_t               merged,
    output logic                 complete,
    output lane_map_t            done_map,
    output logic                 err
);
    qword_t    hold_q;
    lane_map_t done_q;
    lane_map_t sel;
    lane_map_t map_next;
    logic      legal;
    logic      err_q;

    always_comb begin
        legal    = span_legal(ofs, len);
        sel      = span_lanes(ofs, len);
        merged   = place_bytes(hold_q, sel, ofs, data);
        map_next = done_q | sel;
        complete = accept && legal && (&map_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            done_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= accept && !legal;
            if (clear) begin
                done_q <= '0;
            end else if (accept && legal) begin
                hold_q <= merged;
                done_q <= complete ? '0 : map_next;
            end
        end
    end

    assign done_map = done_q;
    assign err      = err_q;
endmodule

// File: rtl/qw_entry_fifo.sv
module qw_entry_fifo
    import qw_asm_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  q_entry_t                   push_entry,
    input  logic                       pop,
    output q_entry_t                   head,
    output logic                       not_empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    q_entry_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign level = count;
endmodule

// File: rtl/qw_assembler.sv
module qw_assembler
    import qw_asm_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    input  logic [3:0]                 wr_lane,
    input  logic [4:0]                 wr_len,
    input  logic [127:0]               wr_data,
    output logic                       wr_err,
    input  logic                       clear_cmd,
    input  logic [31:0]                src_addr,
    input  logic                       rd_pop,
    output logic                       rd_valid,
    output logic [127:0]               rd_data,
    output logic [31:0]                rd_src,
    output logic                       fifo_full,
    output logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    logic      accept;
    logic      complete;
    qword_t    merged;
    lane_map_t done_map;
    logic      pend_q;
    qword_t    pend_data;
    logic      push;
    q_entry_t  head;

    assign wr_ready = !pend_q && !clear_cmd;
    assign accept   = wr_valid && wr_ready;
    assign push     = pend_q && !fifo_full;

    qw_lane_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .clear    (clear_cmd),
        .ofs      (wr_lane),
        .len      (wr_len),
        .data     (wr_data),
        .merged   (merged),
        .complete (complete),
        .done_map (done_map),
        .err      (wr_err)
    );

    // One-entry staging slot between the merge and the queue.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            pend_data <= '0;
        end else if (complete) begin
            pend_q    <= 1'b1;
            pend_data <= merged;
        end else if (push) begin
            pend_q    <= 1'b0;
        end
    end

    qw_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry ('{data: pend_data, src: src_addr}),
        .pop        (rd_pop),
        .head       (head),
        .not_empty  (rd_valid),
        .full       (fifo_full),
        .level      (fifo_level)
    );

    assign rd_data = head.data;
    assign rd_src  = head.src;
endmodule

// File: rtl/qw_assembler_chk.sv
module qw_assembler_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic        wr_err,
    input logic        clear_cmd,
    input logic        rd_pop,
    input logic        rd_valid,
    input logic        fifo_full,
    input logic        pend_valid,
    input logic [15:0] done_map
);
    assert_err_follows_accept_R6: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_valid && wr_ready));

    assert_clear_empties_map_R7: assert property (@(posedge clk) disable iff (rst)
        clear_cmd |=> (done_map == '0));

    assert_full_persists_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !rd_pop) |=> fifo_full);

    assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> !wr_ready);

    assert_complete_clears_map_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_valid) |-> (done_map == '0));

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !wr_err && done_map == '0));
endmodule

bind qw_assembler qw_assembler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_err     (wr_err),
    .clear_cmd  (clear_cmd),
    .rd_pop     (rd_pop),
    .rd_valid   (rd_valid),
    .fifo_full  (fifo_full),
    .pend_valid (pend_q),
    .done_map   (done_map)
);

// File: tb/qw_assembler_tb.sv
module qw_assembler_tb;
    localparam int DEPTH = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [3:0]    wr_lane = '0;
    logic [4:0]    wr_len = '0;
    logic [127:0]  wr_data = '0;
    logic          wr_err;
    logic          clear_cmd = 1'b0;
    logic [31:0]   src_addr = '0;
    logic          rd_pop = 1'b0;
    logic          rd_valid;
    logic [127:0]  rd_data;
    logic [31:0]   rd_src;
    logic          fifo_full;
    logic [LW-1:0] fifo_level;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic        drain    = 1'b0;
    logic        finished = 1'b0;

    logic [159:0] exp_q[$];
    logic [127:0] m_hold = '0;
    logic [15:0]  m_map  = '0;

    always #2.5 clk = ~clk;

    qw_assembler #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_lane(wr_lane), .wr_len(wr_len), .wr_data(wr_data), .wr_err(wr_err),
        .clear_cmd(clear_cmd), .src_addr(src_addr), .rd_pop(rd_pop),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_src(rd_src),
        .fifo_full(fifo_full), .fifo_level(fifo_level)
    );

    task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: waits for the port, drives one write, updates the model.
    task automatic send(input logic [3:0] ofs, input logic [4:0] len,
                        input logic [127:0] data, input logic [31:0] src);
        while (!wr_ready) @(negedge clk);
        src_addr = src;
        wr_valid = 1'b1;
        wr_lane  = ofs;
        wr_len   = len;
        wr_data  = data;
        @(posedge clk);
        if (len != 0 && int'(ofs) + int'(len) <= 16) begin
            for (int l = int'(ofs); l < int'(ofs) + int'(len); l++) begin
                m_hold[l*8 +: 8] = data[(l - int'(ofs))*8 +: 8];
                m_map[l] = 1'b1;
            end
            if (m_map == 16'hFFFF) begin
                exp_q.push_back({m_hold, src});
                m_map = '0;
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear_cmd = 1'b1;
        @(posedge clk);
        m_map = '0;
        @(negedge clk);
        clear_cmd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares every popped head with the scoreboard.
    initial begin
        logic [159:0] e;
        forever begin
            @(negedge clk);
            if (drain && rd_valid && !rst) begin
                if (exp_q.size() == 0) begin
                    check("R2 R9 unexpected entry", {rd_data, rd_src}, '0);
                end else begin
                    e = exp_q.pop_front();
                    check("R1 R3 R4 R5 R9 head entry", {rd_data, rd_src}, e);
                end
                rd_pop = 1'b1;
            end else begin
                rd_pop = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 wr_ready", 160'(wr_ready), 160'(1));
        check("R10 rd_valid", 160'(rd_valid), 160'(0));
        check("R10 wr_err", 160'(wr_err), 160'(0));
        check("R10 fifo_full", 160'(fifo_full), 160'(0));
        check("R10 fifo_level", 160'(fifo_level), 160'(0));
        drain = 1'b1;

        // R1 R3: one full-width write
        send(4'd0, 5'd16, 128'h0f0e0d0c_0b0a0908_07060504_03020100, 32'h1000_0000);
        idle(4);

        // R1 R2: scattered partial writes
        send(4'd5, 5'd3, 128'h00c3c2c1, 32'h2000_0000);
        send(4'd0, 5'd5, 128'hb4b3b2b1b0, 32'h2000_0010);
        idle(4);
        check("R2 no entry while lanes missing", 160'(rd_valid), 160'(0));
        send(4'd8, 5'd8, 128'ha7a6a5a4_a3a2a1a0, 32'h2000_0020);
        idle(4);

        // R5 overwrite of marked lanes
        send(4'd0, 5'd8, 128'h11111111_11111111, 32'h3000_0000);
        send(4'd4, 5'd4, 128'h22222222, 32'h3000_0004);
        send(4'd8, 5'd8, 128'h33333333_33333333, 32'h3000_0008);
        idle(4);

        // R6 rejected writes
        send(4'd0, 5'd12, 128'h5555_5555_5555_5555_5555_5555, 32'h4000_0000);
        send(4'd3, 5'd0, {16{8'hee}}, 32'h4000_0001);
        check("R6 zero length error pulse", 160'(wr_err), 160'(1));
        @(negedge clk);
        check("R6 error lasts one cycle", 160'(wr_err), 160'(0));
        send(4'd12, 5'd8, {16{8'hdd}}, 32'h4000_0002);
        check("R6 boundary crossing error pulse", 160'(wr_err), 160'(1));
        idle(3);
        check("R6 rejected write queues nothing", 160'(rd_valid), 160'(0));
        send(4'd12, 5'd4, 128'h66666666, 32'h4000_0003);
        check("R6 legal write raises no error", 160'(wr_err), 160'(0));
        idle(4);

        // R7 clear discards gathered lanes
        send(4'd0, 5'd8, 128'h77777777_77777777, 32'h5000_0000);
        pulse_clear();
        send(4'd8, 5'd8, 128'h88888888_88888888, 32'h5000_0001);
        idle(4);
        check("R7 cleared lanes must be rewritten", 160'(rd_valid), 160'(0));
        send(4'd0, 5'd8, 128'h99999999_99999999, 32'h5000_0002);
        idle(4);

        // R8 R9 full queue and staging
        drain = 1'b0;
        idle(2);
        for (int i = 0; i <= DEPTH; i++)
            send(4'd0, 5'd16, {16{8'(8'h40 + i)}}, 32'h6000_0000 + i);
        idle(3);
        check("R8 fifo_full", 160'(fifo_full), 160'(1));
        check("R8 fifo_level", 160'(fifo_level), 160'(DEPTH));
        check("R8 wr_ready low while held", 160'(wr_ready), 160'(0));
        drain = 1'b1;
        for (int i = 0; i < 50 && (exp_q.size() != 0 || rd_valid); i++)
            @(negedge clk);
        idle(2);
        check("R8 wr_ready back after drain", 160'(wr_ready), 160'(1));
        check("R9 all entries delivered", 160'(exp_q.size()), 160'(0));
        check("R9 queue empty", 160'(fifo_level), 160'(0));

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule